// File: doc/BRIEF.md
# DMA Channel Error Handler

This block tracks the errors of one DMA channel and makes the channel stop cleanly when one occurs. The channel masters transfers on a PCI-style bus, on either the primary or the secondary side, and reads its descriptors over an internal bus. Four error indications come in: master-abort, target-abort and data parity error from the PCI side, and an error seen while reading a descriptor from the internal bus. Each one sets its own sticky bit in a channel status register. Software clears a bit by writing a one to it.

The block gates the channel's outputs combinationally, in the same cycle as the error. A transfer in progress loses its continue signal, so it ends early. A raised request is withdrawn. A request that has not yet been raised is held back. A write into local memory is suppressed, so data with bad parity never reaches memory.

Each PCI error also sends a one-clock notification to the address translation unit of the bus being mastered. That bus is then remembered, so that retries pending on the other bus can still complete. The channel's active flag drops one clock after an error bit sets. It returns only when software has cleared every error bit and enables the channel again.

Top module: `dma_err_ctl`

## Requirements
- R1: A parity error (`pci_par_err`) while `xfer_active` is high sets status bit 0 at the next clock edge.
- R2: A target-abort (`pci_tgt_abort`) while `xfer_active` is high sets status bit 2 at the next clock edge.
- R3: A master-abort (`pci_mst_abort`) while `xfer_active` is high sets status bit 3 at the next clock edge.
- R4: A descriptor-read error (`ib_desc_err`) sets status bit 5 at the next clock edge, whatever the state of `xfer_active`. Status bits 1, 4, 6 and 7 always read 0.
- R5: When several errors arrive in the same clock, every matching bit sets. PCI error inputs have no effect while `xfer_active` is low.
- R6: Error bits are sticky. A write (`sw_wr_en`) with a 1 in a bit position clears that bit, and a 0 leaves it unchanged. An error that arrives in the same cycle as a clear wins, and the bit stays set.
- R7: `mem_wr_en` is low in any cycle with a qualified parity error, so bad data is never written to local memory.
- R8: A rising qualified PCI error produces exactly one one-clock pulse in the following cycle. The pulse goes on `atu_err_pri` when `bus_sel`=0 and on `atu_err_sec` when `bus_sel`=1. A descriptor-read error produces no pulse.
- R9: `xfer_continue` drops in the same cycle as any error and stays low while any error bit is set.
- R10: `bus_req` is low in the cycle of an error, while any error bit is set, and while the channel is not active. This covers both withdrawing a raised request and never raising a new one.
- R11: `chan_active` falls one clock after an error bit sets. A one-cycle `sw_enable` pulse sets it again only when all error bits are clear and no error is arriving.
- R12: After a PCI error on bus b (0 primary, 1 secondary), `retry_go[b]` is blocked until the status is cleared. `retry_go` for the other bus keeps following `retry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_active | input | 1 | Channel is mastering a PCI data phase |
| bus_sel | input | 1 | Bus being mastered: 0 primary, 1 secondary |
| pci_mst_abort | input | 1 | PCI master-abort indication |
| pci_tgt_abort | input | 1 | PCI target-abort indication |
| pci_par_err | input | 1 | PCI data parity error indication |
| ib_desc_err | input | 1 | Internal-bus error during descriptor read |
| req_in | input | 1 | Channel wants the PCI bus |
| data_wr_en_in | input | 1 | Datapath wants to write local memory |
| retry_in | input | 2 | Pending retry per bus |
| sw_wr_en | input | 1 | Status register write strobe |
| sw_wr_data | input | 8 | Write data, ones clear bits |
| sw_enable | input | 1 | Channel enable pulse |
| status | output | 8 | Channel status register |
| atu_err_pri | output | 1 | Error notification to primary translation unit |
| atu_err_sec | output | 1 | Error notification to secondary translation unit |
| chan_active | output | 1 | Channel running |
| bus_req | output | 1 | Gated bus request |
| xfer_continue | output | 1 | Gated transfer-continue |
| mem_wr_en | output | 1 | Gated local memory write enable |
| retry_go | output | 2 | Gated retry permission per bus |

## Verification
The assertions check on every cycle that each qualified error lands in its own bit one clock later. They also check that the bits are sticky, and that parity errors and recorded errors keep the memory-write and request outputs low. Further per-cycle checks cover the one-clock width of the notification pulses and the fall of the active flag. Only the bench scenarios can show that a pulse is routed to the correct translation unit, and that retries on the bus without an error survive. The same applies to whether a clear colliding with a new error loses, whether ignored PCI errors leave the status untouched, and whether an enable refused while bits are set is also refused for the restart.

// File: rtl/dma_err_pkg.sv
// Shared constants for the DMA channel error handler.
// Assumes an 8-bit status register and two PCI-side buses.
package dma_err_pkg;
    localparam int STAT_W  = 8;
    localparam int NUM_BUS = 2;
    localparam int SEL_W   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1;
    localparam int BIT_PAR = 0;
    localparam int BIT_TAB = 2;
    localparam int BIT_MAB = 3;
    localparam int BIT_IBA = 5;

    typedef struct packed {
        logic par;
        logic tab;
        logic mab;
        logic iba;
    } err_ev_t;

    // Build the status set vector from one cycle's qualified events.
    function automatic logic [STAT_W-1:0] ev_to_vec(input err_ev_t ev);
        logic [STAT_W-1:0] v;
        v = '0;
        v[BIT_PAR] = ev.par;
        v[BIT_TAB] = ev.tab;
        v[BIT_MAB] = ev.mab;
        v[BIT_IBA] = ev.iba;
        return v;
    endfunction

    // Mask of implemented (writable) status bits.
    function automatic logic [STAT_W-1:0] err_mask();
        err_ev_t all;
        all = '{par: 1'b1, tab: 1'b1, mab: 1'b1, iba: 1'b1};
        return ev_to_vec(all);
    endfunction
endpackage

// File: rtl/err_status_reg.sv
// Sticky write-one-to-clear status register.
// Each bit sets on set_vec and clears on clr_vec; a set wins over a clear.
// Assumes the caller masks unimplemented bits out of both vectors.
module err_status_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    output logic [W-1:0] stat_q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        // One sticky status bit with set priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stat_q[i] <= 1'b0;
            else if (set_vec[i])
                stat_q[i] <= 1'b1;
            else if (clr_vec[i])
                stat_q[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/err_notify.sv
// Routes PCI errors to the translation unit of the bus being mastered.
// Emits a one-clock pulse per rising error and remembers the faulted
// bus until the status register is clear. Assumes bus_sel < NB.
module err_notify #(
    parameter int NB    = 2,
    parameter int SEL_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pci_err_now,
    input  logic [SEL_W-1:0] bus_sel,
    input  logic             any_status,
    output logic [NB-1:0]    atu_pulse,
    output logic [NB-1:0]    err_bus
);
    logic prev_q;
    logic rise;

    assign rise = pci_err_now & ~prev_q;

    // Remember the previous cycle's PCI error level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pci_err_now;
    end

    for (genvar b = 0; b < NB; b++) begin : g_bus
        logic hit;
        assign hit = (bus_sel == SEL_W'(b));

        // Notification pulse towards this bus's translation unit.
        always_ff @(posedge clk) begin
            if (!rst_n) atu_pulse[b] <= 1'b0;
            else        atu_pulse[b] <= rise & hit;
        end

        // Faulted-bus marker, dropped once the status register is clear.
        always_ff @(posedge clk) begin
            if (!rst_n) err_bus[b] <= 1'b0;
            else        err_bus[b] <= (any_status & err_bus[b]) | (pci_err_now & hit);
        end
    end
endmodule

// File: rtl/chan_gate.sv
// Run state and output gating for the channel.
// Blocks request, transfer and memory write in the error cycle and
// while errors are recorded; retries are blocked only on faulted buses.
module chan_gate #(
    parameter int NB = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          err_now,
    input  logic          any_status,
    input  logic          sw_enable,
    input  logic          req_in,
    input  logic          xfer_active,
    input  logic          data_wr_en_in,
    input  logic [NB-1:0] retry_in,
    input  logic [NB-1:0] err_bus,
    output logic          chan_active,
    output logic          bus_req,
    output logic          xfer_continue,
    output logic          mem_wr_en,
    output logic [NB-1:0] retry_go
);
    logic run_q;
    logic blocked;

    // Channel run flag: cleared by recorded errors, set by a clean enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_q <= 1'b0;
        else if (any_status)
            run_q <= 1'b0;
        else if (sw_enable && !err_now)
            run_q <= 1'b1;
    end

    // Combinational stop condition covering all three bus-cycle stages.
    always_comb begin
        blocked       = err_now | any_status | ~run_q;
        bus_req       = req_in & ~blocked;
        xfer_continue = xfer_active & ~blocked;
        mem_wr_en     = data_wr_en_in & ~blocked;
        retry_go      = retry_in & ~err_bus;
    end

    assign chan_active = run_q;
endmodule

// File: rtl/dma_err_ctl.sv
// Top of the DMA channel error handler. Qualifies error inputs,
// records them in the status register, notifies translation units
// and gates the channel. Assumes error inputs are synchronous to clk.
module dma_err_ctl
    import dma_err_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xfer_active,
    input  logic [SEL_W-1:0]     bus_sel,
    input  logic                 pci_mst_abort,
    input  logic                 pci_tgt_abort,
    input  logic                 pci_par_err,
    input  logic                 ib_desc_err,
    input  logic                 req_in,
    input  logic                 data_wr_en_in,
    input  logic [NUM_BUS-1:0]   retry_in,
    input  logic                 sw_wr_en,
    input  logic [STAT_W-1:0]    sw_wr_data,
    input  logic                 sw_enable,
    output logic [STAT_W-1:0]    status,
    output logic                 atu_err_pri,
    output logic                 atu_err_sec,
    output logic                 chan_active,
    output logic                 bus_req,
    output logic                 xfer_continue,
    output logic                 mem_wr_en,
    output logic [NUM_BUS-1:0]   retry_go
);
    localparam logic [STAT_W-1:0] MASK = err_mask();

    err_ev_t             ev;
    logic [STAT_W-1:0]   set_vec;
    logic [STAT_W-1:0]   clr_vec;
    logic                pci_err_now;
    logic                err_now;
    logic                any_status;
    logic [NUM_BUS-1:0]  atu_pulse;
    logic [NUM_BUS-1:0]  err_bus;

    // Qualify events: PCI errors count only during an active transfer.
    always_comb begin
        ev.par      = pci_par_err   & xfer_active;
        ev.tab      = pci_tgt_abort & xfer_active;
        ev.mab      = pci_mst_abort & xfer_active;
        ev.iba      = ib_desc_err;
        pci_err_now = ev.par | ev.tab | ev.mab;
        err_now     = pci_err_now | ev.iba;
        set_vec     = ev_to_vec(ev);
        clr_vec     = sw_wr_en ? (sw_wr_data & MASK) : '0;
        any_status  = |status;
    end

    err_status_reg #(.W(STAT_W)) u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .stat_q  (status)
    );

    err_notify #(.NB(NUM_BUS), .SEL_W(SEL_W)) u_notify (
        .clk         (clk),
        .rst_n       (rst_n),
        .pci_err_now (pci_err_now),
        .bus_sel     (bus_sel),
        .any_status  (any_status),
        .atu_pulse   (atu_pulse),
        .err_bus     (err_bus)
    );

    chan_gate #(.NB(NUM_BUS)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .err_now       (err_now),
        .any_status    (any_status),
        .sw_enable     (sw_enable),
        .req_in        (req_in),
        .xfer_active   (xfer_active),
        .data_wr_en_in (data_wr_en_in),
        .retry_in      (retry_in),
        .err_bus       (err_bus),
        .chan_active   (chan_active),
        .bus_req       (bus_req),
        .xfer_continue (xfer_continue),
        .mem_wr_en     (mem_wr_en),
        .retry_go      (retry_go)
    );

    assign atu_err_pri = atu_pulse[0];
    assign atu_err_sec = atu_pulse[1];
endmodule

// File: rtl/dma_err_ctl_chk.sv
// Checker for dma_err_ctl, observing ports only. Bound to every instance.
module dma_err_ctl_chk
    import dma_err_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               xfer_active,
    input logic               pci_mst_abort,
    input logic               pci_tgt_abort,
    input logic               pci_par_err,
    input logic               ib_desc_err,
    input logic               sw_wr_en,
    input logic [STAT_W-1:0]  sw_wr_data,
    input logic [STAT_W-1:0]  status,
    input logic               atu_err_pri,
    input logic               atu_err_sec,
    input logic               chan_active,
    input logic               bus_req,
    input logic               xfer_continue,
    input logic               mem_wr_en
);
    a_r1_par_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pci_par_err && xfer_active |=> status[BIT_PAR]);
    a_r2_tab_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pci_tgt_abort && xfer_active |=> status[BIT_TAB]);
    a_r3_mab_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pci_mst_abort && xfer_active |=> status[BIT_MAB]);
    a_r4_iba_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ib_desc_err |=> status[BIT_IBA]);
    a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[1] == 1'b0 && status[4] == 1'b0 && status[7:6] == 2'b00);
    a_r6_sticky_mab: assert property (@(posedge clk) disable iff (!rst_n)
        status[BIT_MAB] && !(sw_wr_en && sw_wr_data[BIT_MAB]) |=> status[BIT_MAB]);
    a_r7_par_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        pci_par_err && xfer_active |-> !mem_wr_en);
    a_r8_pulse_one_clk: assert property (@(posedge clk) disable iff (!rst_n)
        atu_err_pri || atu_err_sec |=> !atu_err_pri && !atu_err_sec);
    a_r9_no_continue: assert property (@(posedge clk) disable iff (!rst_n)
        (|status) |-> !xfer_continue);
    a_r10_no_request: assert property (@(posedge clk) disable iff (!rst_n)
        (|status) || !chan_active |-> !bus_req);
    a_r11_active_falls: assert property (@(posedge clk) disable iff (!rst_n)
        (|status) |=> !chan_active);
endmodule

bind dma_err_ctl dma_err_ctl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .xfer_active   (xfer_active),
    .pci_mst_abort (pci_mst_abort),
    .pci_tgt_abort (pci_tgt_abort),
    .pci_par_err   (pci_par_err),
    .ib_desc_err   (ib_desc_err),
    .sw_wr_en      (sw_wr_en),
    .sw_wr_data    (sw_wr_data),
    .status        (status),
    .atu_err_pri   (atu_err_pri),
    .atu_err_sec   (atu_err_sec),
    .chan_active   (chan_active),
    .bus_req       (bus_req),
    .xfer_continue (xfer_continue),
    .mem_wr_en     (mem_wr_en)
);

// File: tb/sim_dma_err_ctl.sv
module sim_dma_err_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xa = 0, bsel = 0, mab = 0, tab = 0, par = 0, iba = 0;
    logic req = 0, dwr = 0, swe = 0, sen = 0;
    logic [1:0] rty = 0;
    logic [7:0] swd = 0;

    logic [7:0] status;
    logic apri, asec, act, breq, xcont, mwr;
    logic [1:0] rgo;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // Reference model state.
    int m_stat = 0, m_run = 0, m_prev = 0, m_pri = 0, m_sec = 0, m_ebus = 0;

    always #4 clk = ~clk;

    dma_err_ctl u0 (
        .clk(clk), .rst_n(rst_n), .xfer_active(xa), .bus_sel(bsel),
        .pci_mst_abort(mab), .pci_tgt_abort(tab), .pci_par_err(par),
        .ib_desc_err(iba), .req_in(req), .data_wr_en_in(dwr),
        .retry_in(rty), .sw_wr_en(swe), .sw_wr_data(swd), .sw_enable(sen),
        .status(status), .atu_err_pri(apri), .atu_err_sec(asec),
        .chan_active(act), .bus_req(breq), .xfer_continue(xcont),
        .mem_wr_en(mwr), .retry_go(rgo)
    );

    task automatic chk(input string req_tag, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s cycle %0d: actual %0h expected %0h", req_tag, cyc, act_v, exp_v);
        end
    endtask

    // Advance the model by one clock edge using the held inputs.
    task automatic model_step();
        int qp, qt, qm, pci, setv, clrv, hit;
        if (!rst_n) begin
            m_stat = 0; m_run = 0; m_prev = 0; m_pri = 0; m_sec = 0; m_ebus = 0;
            return;
        end
        qp = par & xa; qt = tab & xa; qm = mab & xa;
        pci = qp | qt | qm;
        setv = qp | (qt << 2) | (qm << 3) | (int'(iba) << 5);
        clrv = swe ? (int'(swd) & 8'h2D) : 0;
        hit = bsel ? 2 : 1;
        m_pri = (pci && !m_prev && !bsel) ? 1 : 0;
        m_sec = (pci && !m_prev && bsel) ? 1 : 0;
        m_prev = pci;
        m_ebus = ((m_stat != 0) ? m_ebus : 0) | (pci ? hit : 0);
        if (m_stat != 0) m_run = 0;
        else if (sen && !(pci || iba)) m_run = 1;
        m_stat = (m_stat & ~clrv) | setv;
    endtask

    // Compare every output against the model; tag names the status requirement.
    task automatic compare(input string tag);
        int errn, blk;
        errn = ((par | tab | mab) & xa) | iba;
        blk = errn || (m_stat != 0) || !m_run;
        chk(tag, status, m_stat);
        chk("R8 atu_err_pri", apri, m_pri);
        chk("R8 atu_err_sec", asec, m_sec);
        chk("R11 chan_active", act, m_run);
        chk("R10 bus_req", breq, req & !blk);
        chk("R9 xfer_continue", xcont, xa & !blk);
        chk("R7 mem_wr_en", mwr, dwr & !blk);
        chk("R12 retry_go", rgo, rty & ~m_ebus[1:0]);
    endtask

    task automatic tick(input string tag);
        @(posedge clk);
        model_step();
        cyc++;
        @(negedge clk);
        compare(tag);
    endtask

    task automatic quiet();
        mab = 0; tab = 0; par = 0; iba = 0; swe = 0; swd = 0; sen = 0;
    endtask

    task automatic clear_and_enable();
        quiet(); swe = 1; swd = 8'hFF; tick("R6 clear all");
        quiet(); sen = 1; tick("R11 enable");
        quiet(); tick("R11 idle");
    endtask

    initial begin
        // Watchdog: a hung run counts as a failure.
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        tick("R6 reset"); tick("R6 reset");
        rst_n = 1;
        tick("R6 after reset");
        sen = 1; tick("R11 enable"); quiet();
        req = 1; xa = 1; dwr = 1; rty = 2'b11;
        tick("R10 normal"); tick("R9 normal");
        // Parity on primary bus.
        par = 1; bsel = 0; tick("R1 parity"); quiet();
        tick("R1 parity recorded"); tick("R8 after pulse");
        // Writing zeros has no effect.
        swe = 1; swd = 8'h00; tick("R6 write zero"); quiet();
        clear_and_enable();
        // Target abort on secondary; retry on primary must survive.
        bsel = 1; tab = 1; tick("R2 target abort"); quiet();
        tick("R12 secondary blocked"); tick("R2 recorded");
        // Enable while bits set is refused.
        sen = 1; tick("R11 enable refused"); quiet(); tick("R11 still idle");
        clear_and_enable();
        // Master abort on primary.
        bsel = 0; mab = 1; tick("R3 master abort"); quiet();
        tick("R3 recorded"); tick("R12 primary blocked");
        clear_and_enable();
        // PCI errors with no transfer are ignored.
        xa = 0; mab = 1; tab = 1; par = 1; tick("R5 ignored"); quiet();
        tick("R5 ignored status"); tick("R10 still requesting");
        // Descriptor error: no notification.
        iba = 1; tick("R4 descriptor error"); quiet(); tick("R4 recorded");
        tick("R8 no pulse");
        clear_and_enable();
        // All errors at once.
        xa = 1; mab = 1; tab = 1; par = 1; iba = 1; tick("R5 all errors"); quiet();
        tick("R5 all recorded"); tick("R5 held");
        // Clear colliding with a new parity error.
        swe = 1; swd = 8'hFF; par = 1; tick("R6 set beats clear"); quiet();
        tick("R6 after collision");
        clear_and_enable();
        // Sustained error gives a single pulse.
        bsel = 1; mab = 1; tick("R8 sustained 1"); tick("R8 sustained 2");
        tick("R8 sustained 3"); quiet(); tick("R8 sustained end");
        clear_and_enable();
        // Partial clear leaves other bits.
        par = 1; iba = 1; tick("R5 two errors"); quiet();
        swe = 1; swd = 8'h01; tick("R6 partial clear"); quiet();
        tick("R6 bit5 remains");
        clear_and_enable();
        tick("R10 resume");
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule